// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level page table stored in memory. The virtual address is cut into three fields: a 10-bit index into the top-level (directory) table, a 10-bit index into a second-level (leaf) table, and a 12-bit byte offset within the page. The walker first fetches the directory entry. That entry names the physical page that holds the leaf table. The walker then fetches the leaf entry, which names the target frame. It joins that frame with the offset to form the result.

A client raises a request with the virtual address while the walker is idle. The directory base address is sampled from an input at the moment the request is taken. Memory is reached through a read port that has a single request in flight at a time: a valid/ready request phase, then a one-cycle response strobe. Each entry is 32 bits wide and carries a presence flag in bit 0. An entry whose flag is clear stops the walk and produces a fault that reports the level where the walk stopped. A full translation costs two table reads before the client can make its own data access.

Top module: `ptw_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `mem_req_valid` is 0 and `done_valid` is 0.
- R2: The first read of a walk targets `tbl_base + 4 * va[31:22]`.
- R3: After a directory entry with bit 0 set, the second read targets `{dir_entry[31:12], va[21:12], 2'b00}`.
- R4: When both entries have bit 0 set, the result is `done_pa = {leaf_entry[31:12], va[11:0]}` with `done_fault = 0`, after exactly two memory reads. Entry bits 11:1 have no effect.
- R5: A directory entry with bit 0 clear ends the walk after one read, with `done_fault = 1`, `fault_level = 0` and `done_pa = 0`.
- R6: A leaf entry with bit 0 clear ends the walk after two reads, with `done_fault = 1`, `fault_level = 1` and `done_pa = 0`.
- R7: `done_valid` is high for exactly one cycle per walk. `req_ready` is low from the cycle after a request is taken through the `done_valid` cycle. A request held or changed during that time is neither taken nor allowed to alter the current result.
- R8: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. A new read is never issued while a response is still owed.
- R9: A `mem_rsp_valid` pulse that arrives when no read is outstanding is ignored. The walker stays idle and later walks are unaffected.
- R10: `done_pa`, `done_fault` and `fault_level` keep their values between `done_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Physical base of the directory table, sampled with the request |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done_valid | output | 1 | One-cycle completion strobe |
| done_fault | output | 1 | Walk ended on an entry with bit 0 clear |
| fault_level | output | 1 | 0 = directory entry, 1 = leaf entry |
| done_pa | output | 32 | Translated physical address (0 on fault) |

## Verification
Two things can meet in the same cycle: the completion strobe, and a client request that has been waiting. The bench keeps `req_valid` high with a second address through a whole walk. It then checks three things: the first result belongs to the first address, `req_ready` is low while `done_valid` is high, and the waiting request is taken only in the cycle after that and returns its own translation. A second overlap is a stray memory response landing while the walker is idle or while a request is still unaccepted. The bench injects one, then checks that no strobe follows and that the next walk reads the expected addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    W_IDLE  = 3'd0,
    W_OUTER = 3'd1,
    W_INNER = 3'd2,
    W_DONE  = 3'd3,
    W_FAULT = 3'd4
  } walk_state_e;

  typedef enum logic {
    LVL_DIR  = 1'b0,
    LVL_LEAF = 1'b1
  } fault_lvl_e;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int OUTER_W     = 10,
  parameter int INNER_W     = 10,
  parameter int OFS_W       = 12,
  parameter int PA_W        = 32,
  parameter int ENTRY_BYTES = 4,
  localparam int VA_W       = OUTER_W + INNER_W + OFS_W,
  localparam int FRAME_W    = PA_W - OFS_W
) (
  input  logic [VA_W-1:0]    va,
  input  logic [PA_W-1:0]    base,
  input  logic [FRAME_W-1:0] frame,
  output logic [OFS_W-1:0]   offset,
  output logic [PA_W-1:0]    outer_addr,
  output logic [PA_W-1:0]    inner_addr
);
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);

  logic [OUTER_W-1:0] outer_idx;
  logic [INNER_W-1:0] inner_idx;
  logic [PA_W-1:0]    outer_scaled;
  logic [PA_W-1:0]    inner_scaled;

  always_comb begin
    outer_idx    = va[VA_W-1 -: OUTER_W];
    inner_idx    = va[OFS_W +: INNER_W];
    offset       = va[OFS_W-1:0];
    outer_scaled = {{(PA_W-OUTER_W){1'b0}}, outer_idx} << ENTRY_SH;
    inner_scaled = {{(PA_W-INNER_W){1'b0}}, inner_idx} << ENTRY_SH;
    outer_addr   = base + outer_scaled;
    inner_addr   = {frame, {OFS_W{1'b0}}} + inner_scaled;
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_va,
  output logic               req_ready,
  output logic [VA_W-1:0]    va_sel,
  input  logic [PA_W-1:0]    outer_addr,
  input  logic [PA_W-1:0]    inner_addr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic               rsp_present,
  input  logic [FRAME_W-1:0] rsp_frame,
  output logic               cap_en,
  output logic               cap_fault,
  output fault_lvl_e         cap_level,
  output logic [FRAME_W-1:0] cap_frame
);

  walk_state_e     state_q;
  walk_state_e     state_d;
  logic [VA_W-1:0] va_q;
  logic            rd_pend_q;
  logic            take_rsp;
  logic            hs;

  assign req_ready = (state_q == W_IDLE);
  assign va_sel    = (state_q == W_IDLE) ? req_va : va_q;
  assign hs        = mem_req_valid && mem_req_ready;
  assign take_rsp  = rd_pend_q && mem_rsp_valid;

  always_comb begin
    state_d   = state_q;
    cap_en    = 1'b0;
    cap_fault = 1'b0;
    cap_level = LVL_DIR;
    cap_frame = rsp_frame;
    unique case (state_q)
      W_IDLE:  if (req_valid) state_d = W_OUTER;
      W_OUTER: if (take_rsp) begin
        if (rsp_present) begin
          state_d = W_INNER;
        end else begin
          state_d   = W_FAULT;
          cap_en    = 1'b1;
          cap_fault = 1'b1;
          cap_level = LVL_DIR;
        end
      end
      W_INNER: if (take_rsp) begin
        cap_en    = 1'b1;
        cap_level = LVL_LEAF;
        if (rsp_present) begin
          state_d = W_DONE;
        end else begin
          state_d   = W_FAULT;
          cap_fault = 1'b1;
        end
      end
      W_DONE:  state_d = W_IDLE;
      W_FAULT: state_d = W_IDLE;
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= W_IDLE;
      va_q          <= '0;
      rd_pend_q     <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      state_q <= state_d;
      if (hs) begin
        mem_req_valid <= 1'b0;
        rd_pend_q     <= 1'b1;
      end
      if (take_rsp) rd_pend_q <= 1'b0;
      if (state_q == W_IDLE && req_valid) begin
        va_q          <= req_va;
        mem_req_valid <= 1'b1;
        mem_req_addr  <= outer_addr;
      end
      if (state_q == W_OUTER && take_rsp && rsp_present) begin
        mem_req_valid <= 1'b1;
        mem_req_addr  <= inner_addr;
      end
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pend_q |-> !mem_req_valid);

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == W_IDLE && !req_valid && mem_rsp_valid) |=> (state_q == W_IDLE));

endmodule

// File: rtl/ptw_result.sv
module ptw_result
  import ptw_pkg::*;
#(
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_en,
  input  logic               cap_fault,
  input  fault_lvl_e         cap_level,
  input  logic [FRAME_W-1:0] cap_frame,
  input  logic [OFS_W-1:0]   offset,
  output logic               done_valid,
  output logic               done_fault,
  output logic               fault_level,
  output logic [PA_W-1:0]    done_pa
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid  <= 1'b0;
      done_fault  <= 1'b0;
      fault_level <= 1'b0;
      done_pa     <= '0;
    end else begin
      done_valid <= cap_en;
      if (cap_en) begin
        done_fault  <= cap_fault;
        fault_level <= cap_fault && (cap_level == LVL_LEAF);
        done_pa     <= cap_fault ? '0 : {cap_frame, offset};
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_valid |-> ($stable(done_pa) && $stable(done_fault) && $stable(fault_level)));

  // R5
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_fault) |-> (done_pa == '0));

endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int OUTER_W     = 10,
  parameter int INNER_W     = 10,
  parameter int OFS_W       = 12,
  parameter int PA_W        = 32,
  parameter int PTE_W       = 32,
  parameter int ENTRY_BYTES = 4,
  localparam int VA_W       = OUTER_W + INNER_W + OFS_W,
  localparam int FRAME_W    = PA_W - OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [PA_W-1:0]  tbl_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done_valid,
  output logic             done_fault,
  output logic             fault_level,
  output logic [PA_W-1:0]  done_pa
);

  logic [VA_W-1:0]    va_sel;
  logic [OFS_W-1:0]   offset;
  logic [PA_W-1:0]    outer_addr;
  logic [PA_W-1:0]    inner_addr;
  logic [FRAME_W-1:0] rsp_frame;
  logic               rsp_present;
  logic               cap_en;
  logic               cap_fault;
  fault_lvl_e         cap_level;
  logic [FRAME_W-1:0] cap_frame;

  assign rsp_frame   = mem_rsp_data[PTE_W-1 -: FRAME_W];
  assign rsp_present = mem_rsp_data[0];

  ptw_va_split #(
    .OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFS_W(OFS_W),
    .PA_W(PA_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_split (
    .va(va_sel), .base(tbl_base), .frame(rsp_frame),
    .offset(offset), .outer_addr(outer_addr), .inner_addr(inner_addr)
  );

  ptw_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
    .va_sel(va_sel), .outer_addr(outer_addr), .inner_addr(inner_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .rsp_present(rsp_present), .rsp_frame(rsp_frame),
    .cap_en(cap_en), .cap_fault(cap_fault), .cap_level(cap_level),
    .cap_frame(cap_frame)
  );

  ptw_result #(.PA_W(PA_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W)) u_result (
    .clk(clk), .rst(rst),
    .cap_en(cap_en), .cap_fault(cap_fault), .cap_level(cap_level),
    .cap_frame(cap_frame), .offset(offset),
    .done_valid(done_valid), .done_fault(done_fault),
    .fault_level(fault_level), .done_pa(done_pa)
  );

endmodule

// File: tb/ptw_top_test.sv
module ptw_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pa;
    logic        flt;
    logic        lvl;
    logic [1:0]  reads;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0123, 32'hABCD_E123, 1'b0, 1'b0, 2'd2},
    '{32'h003F_FFFF, 32'h1234_5FFF, 1'b0, 1'b0, 2'd2},
    '{32'hFFFF_F000, 32'hFFFF_F000, 1'b0, 1'b0, 2'd2},
    '{32'h0140_1456, 32'h0000_0000, 1'b1, 1'b1, 2'd2},
    '{32'h0140_2ABC, 32'h0000_0000, 1'b1, 1'b1, 2'd2},
    '{32'h01C0_07FF, 32'h0000_0000, 1'b1, 1'b0, 2'd1}
  };

  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0;
  logic req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] tbl_base = BASE;
  logic mem_req_valid;
  logic mem_req_ready = 1;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;
  logic done_valid, done_fault, fault_level;
  logic [31:0] done_pa;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] mem [8192];
  logic [31:0] addr_log [4];
  int hs_cnt = 0;
  int overlap = 0;
  bit pend = 0;
  int cnt = 0;
  int lat = 0;
  bit stall = 0;
  bit inject = 0;
  logic [12:0] pend_idx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_top uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .tbl_base(tbl_base), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault),
    .fault_level(fault_level), .done_pa(done_pa)
  );

  // behavioural memory, driven at falling edges
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (inject) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = 32'hFFFF_FFFF;
        inject = 0;
      end else if (pend && cnt == 0) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = mem[pend_idx];
        pend = 0;
      end else if (pend) begin
        cnt--;
      end
      mem_req_ready = stall ? ~mem_req_ready : 1'b1;
      if (mem_req_valid && pend) overlap++;
      if (mem_req_valid && mem_req_ready && !rst) begin
        pend = 1;
        cnt = lat;
        pend_idx = mem_req_addr[14:2];
        if (hs_cnt < 4) addr_log[hs_cnt] = mem_req_addr;
        hs_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (!done_valid && waited < 500) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic run_walk(input logic [31:0] va, output logic [31:0] pa,
                          output logic flt, output logic lvl, output int reads,
                          output int width);
    int w;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    hs_cnt = 0;
    req_va = va;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    wait_done(w);
    pa = done_pa;
    flt = done_fault;
    lvl = fault_level;
    reads = hs_cnt;
    @(negedge clk);
    width = done_valid ? 2 : 1;
  endtask

  function automatic logic [31:0] exp_a0(input logic [31:0] va);
    return BASE + {20'd0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] exp_a1(input logic [31:0] va);
    logic [31:0] d;
    d = mem[exp_a0(va) >> 2];
    return {d[31:12], va[21:12], 2'b00};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] pa, pa2, held;
    logic flt, lvl;
    int reads, width, w;

    for (int i = 0; i < 8192; i++) mem[i] = '0;
    mem[(32'h1000 >> 2) + 0]     = 32'h0000_2001;
    mem[(32'h1000 >> 2) + 10'h3FF] = 32'h0000_3001;
    mem[(32'h1000 >> 2) + 5]     = 32'h0000_4FFF;
    mem[(32'h2000 >> 2) + 0]     = 32'hABCD_E001;
    mem[(32'h2000 >> 2) + 10'h3FF] = 32'h1234_5FFF;
    mem[(32'h3000 >> 2) + 10'h3FF] = 32'hFFFF_F001;
    mem[(32'h4000 >> 2) + 1]     = 32'h0000_0000;
    mem[(32'h4000 >> 2) + 2]     = 32'hFFFF_FFFE;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1", "req_ready in reset", {31'd0, req_ready}, 1);
    rst = 0;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_req_valid === 1'b0 && done_valid === 1'b0,
        "R1", "idle outputs after reset", {29'd0, req_ready, mem_req_valid, done_valid}, 32'h4);

    // table of vectors, without and with stalls/latency
    for (int mode = 0; mode < 2; mode++) begin
      stall = (mode == 1);
      lat = (mode == 1) ? 2 : 0;
      for (int v = 0; v < 6; v++) begin
        run_walk(VECS[v].va, pa, flt, lvl, reads, width);
        chk(addr_log[0] === exp_a0(VECS[v].va), "R2", "directory read address",
            addr_log[0], exp_a0(VECS[v].va));
        if (VECS[v].reads == 2)
          chk(addr_log[1] === exp_a1(VECS[v].va), "R3", "leaf read address",
              addr_log[1], exp_a1(VECS[v].va));
        chk(reads == int'(VECS[v].reads), VECS[v].flt ? (VECS[v].lvl ? "R6" : "R5") : "R4",
            "read count", reads, {30'd0, VECS[v].reads});
        chk(flt === VECS[v].flt && (!flt || lvl === VECS[v].lvl),
            VECS[v].flt ? (VECS[v].lvl ? "R6" : "R5") : "R4", "fault/level",
            {30'd0, flt, lvl}, {30'd0, VECS[v].flt, VECS[v].lvl});
        chk(pa === VECS[v].pa, VECS[v].flt ? "R5" : "R4", "physical address", pa, VECS[v].pa);
        chk(width == 1, "R7", "done pulse width", width, 1);
      end
    end
    stall = 0;
    lat = 1;

    // R7: request held through busy period, coincident with completion
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    hs_cnt = 0;
    req_va = VECS[0].va;
    req_valid = 1;
    @(negedge clk);
    req_va = VECS[2].va;
    chk(req_ready === 1'b0, "R7", "busy after accept", {31'd0, req_ready}, 0);
    wait_done(w);
    pa = done_pa;
    chk(pa === VECS[0].pa, "R7", "first result unaffected by held request", pa, VECS[0].pa);
    chk(req_ready === 1'b0, "R7", "not ready during done strobe", {31'd0, req_ready}, 0);
    chk(hs_cnt == 2, "R7", "no extra reads while busy", hs_cnt, 2);
    hs_cnt = 0;
    @(negedge clk);
    chk(req_ready === 1'b1 && done_valid === 1'b0, "R7", "idle after strobe",
        {30'd0, req_ready, done_valid}, 32'h2);
    @(negedge clk);
    req_valid = 0;
    wait_done(w);
    pa2 = done_pa;
    chk(pa2 === VECS[2].pa, "R7", "waiting request translated", pa2, VECS[2].pa);
    chk(addr_log[0] === exp_a0(VECS[2].va), "R2", "waiting request address",
        addr_log[0], exp_a0(VECS[2].va));

    // R10 result held while idle
    held = done_pa;
    repeat (6) @(negedge clk);
    chk(done_pa === held && done_fault === 1'b0, "R10", "result held", done_pa, held);

    // R9 stray response while idle
    hs_cnt = 0;
    @(negedge clk);
    inject = 1;
    repeat (4) begin
      @(negedge clk);
      chk(req_ready === 1'b1 && done_valid === 1'b0, "R9", "stray response ignored",
          {30'd0, req_ready, done_valid}, 32'h2);
    end
    chk(done_pa === held, "R9", "result unchanged by stray response", done_pa, held);
    run_walk(VECS[1].va, pa, flt, lvl, reads, width);
    chk(pa === VECS[1].pa && flt === 1'b0, "R9", "walk after stray response", pa, VECS[1].pa);
    chk(reads == 2, "R9", "reads after stray response", reads, 2);

    // R8 never a second read while one is owed
    chk(overlap == 0, "R8", "request while response owed", overlap, 0);

    finish_run();
  end

endmodule